// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Lookaside Buffer

This block holds recently used virtual-to-physical page translations so that a processor can turn a virtual address into a physical one without going to memory. The defaults give a 40-bit virtual address, a 36-bit physical address and 16 KB pages. That leaves a 14-bit page offset, a 26-bit virtual page number and a 22-bit physical page number. The page number is split into an 8-bit set index (256 sets) and an 18-bit tag, and each set holds two ways. A lookup is combinational: in the cycle it is accepted, the block either returns the physical address or reports a miss. Every hit is also checked against the entry's 2-bit access-control field.

The block never walks a page table. A miss is a signal to trap-handling software, which then installs the translation through the fill stream. The block picks the way that the fill replaces. Each entry also tracks a reference bit and a dirty bit. Software can clear every reference bit at once to approximate least-recently-used eviction. The first write to a clean page is reported so that software learns the page is now modified.

Both streams use valid/ready. A lookup is accepted in a cycle where `lk_valid` and `lk_ready` are both high. A fill is accepted in a cycle where `fill_valid` and `fill_ready` are both high. Both ready signals drop only in a cycle where `inv_all` is high. A source held off by a low ready must keep its request stable until it is accepted. All result outputs are valid only in the cycle of acceptance.

Top module: `tlb2w_xlate`

## Requirements
- R1: After reset every entry is invalid. Every accepted lookup misses (`lk_miss`=1, `lk_hit`=0) until a fill is made, and both ready outputs are high.
- R2: The set index is `lk_vaddr[21:14]` and the tag is `lk_vaddr[39:22]`. An accepted lookup that matches a valid entry in exactly one way raises `lk_hit` and drives `lk_paddr` = {entry page number, `lk_vaddr[13:0]`} in the same cycle. `lk_hit` and `lk_miss` are never high together.
- R3: An accepted lookup with no matching valid entry raises `lk_miss`, drives `lk_paddr` to zero and changes no stored state.
- R4: The access codes are: 0 no access, 1 read-only, 2 read/write, 3 read/execute. The lookup kinds are: 0 read, 1 write, 2 execute, 3 reserved. A read is allowed under codes 1, 2 and 3. A write is allowed only under code 2, and an execute only under code 3. The reserved kind is never allowed. A disallowed hit raises `lk_fault` with `lk_hit` still high and updates neither the reference bit nor the dirty bit.
- R5: An allowed hit sets the entry's reference bit, and a fill clears it. `ref_clr` clears every reference bit in one cycle and takes precedence over a hit in the same cycle.
- R6: An allowed write hit on an entry whose dirty bit is clear raises `lk_wr_clean` in that cycle and sets the dirty bit. Later writes to the same entry do not raise it. A fill installs the dirty bit given by `fill_dirty`.
- R7: A fill into a set writes way 0 if way 0 is invalid, else way 1 if way 1 is invalid. With both ways valid, it writes the way whose reference bit is clear. If the two reference bits are equal, it writes way 0.
- R8: `inv_all` clears every valid bit in one cycle. During that cycle both `lk_ready` and `fill_ready` are low, and every lookup accepted in a later cycle misses until new fills are made.
- R9: If both ways of the looked-up set match the tag, the lookup reports `lk_miss` and `lk_multi`, with `lk_hit` low.
- R10: When no lookup is accepted, `lk_hit`, `lk_miss`, `lk_fault`, `lk_wr_clean` and `lk_multi` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vaddr | input | VA_W (40) | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found in exactly one way |
| lk_miss | output | 1 | No usable translation; trap to software |
| lk_fault | output | 1 | Hit whose access code forbids this kind |
| lk_wr_clean | output | 1 | First write to a clean page |
| lk_multi | output | 1 | Both ways matched the same tag |
| lk_paddr | output | PA_W (36) | Translated physical address, zero unless hit |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | VA_W-14 (26) | Virtual page number to install |
| fill_ppn | input | PA_W-14 (22) | Physical page number to install |
| fill_acc | input | 2 | Access code to install |
| fill_dirty | input | 1 | Initial dirty bit |
| inv_all | input | 1 | Invalidate every entry |
| ref_clr | input | 1 | Clear every reference bit |

## Verification
The assertions check the cycle-local rules on every cycle. These are: hit and miss exclusion, a multi-match always reading as a miss, a fault only ever accompanying a hit, silence when no lookup is accepted, a miss on every lookup in the cycle after an invalidate, and no second write-to-clean report for the same address in back-to-back cycles. The victim choice, the precedence of reference clearing over a same-cycle hit, and the address arithmetic across all sets can only be shown by the bench's fill-and-evict scenarios and its sweep of every access code against every lookup kind.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2,
    ACC_RX   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  localparam int unsigned TLB_WAYS = 2;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int unsigned SET_BITS = 8,
  parameter int unsigned TAG_W    = 18,
  parameter int unsigned PPN_W    = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  // lookup-side read
  input  logic [SET_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [PPN_W-1:0]    rd_ppn,
  output logic [1:0]          rd_acc,
  output logic                rd_dirty,
  // fill-side read for victim choice
  input  logic [SET_BITS-1:0] fl_idx,
  output logic                fl_valid,
  output logic                fl_ref,
  // install
  input  logic                wr_en,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [1:0]          wr_acc,
  input  logic                wr_dirty,
  // usage marking
  input  logic                mark_en,
  input  logic                mark_dirty,
  // global operations
  input  logic                inv_all,
  input  logic                ref_clr
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q, dirty_q, ref_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];
  logic [1:0]       acc_q [SETS];

  // State bits: the fill is written last so it wins over marking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else begin
      if (inv_all) valid_q <= '0;
      else if (wr_en) valid_q[fl_idx] <= 1'b1;

      if (ref_clr) ref_q <= '0;
      else if (mark_en) ref_q[rd_idx] <= 1'b1;

      if (mark_en && mark_dirty) dirty_q[rd_idx] <= 1'b1;

      if (wr_en) begin
        ref_q[fl_idx]   <= 1'b0;
        dirty_q[fl_idx] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[fl_idx] <= wr_tag;
      ppn_q[fl_idx] <= wr_ppn;
      acc_q[fl_idx] <= wr_acc;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_ppn   = ppn_q[rd_idx];
  assign rd_acc   = acc_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign fl_valid = valid_q[fl_idx];
  assign fl_ref   = ref_q[fl_idx];
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim (
  input  logic [1:0] way_valid,
  input  logic [1:0] way_ref,
  output logic       victim
);
  always_comb begin
    if (!way_valid[0])      victim = 1'b0;
    else if (!way_valid[1]) victim = 1'b1;
    else if (!way_ref[0])   victim = 1'b0;
    else if (!way_ref[1])   victim = 1'b1;
    else                    victim = 1'b0;
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [1:0] kind,
  output logic       allowed
);
  always_comb begin
    unique case (kind_e'(kind))
      KIND_READ:  allowed = (acc_e'(acc) != ACC_NONE);
      KIND_WRITE: allowed = (acc_e'(acc) == ACC_RW);
      KIND_EXEC:  allowed = (acc_e'(acc) == ACC_RX);
      default:    allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb2w_xlate.sv
module tlb2w_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 40,
  parameter int unsigned PA_W      = 36,
  parameter int unsigned PAGE_BITS = 14,
  parameter int unsigned SET_BITS  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  output logic                      lk_ready,
  input  logic [VA_W-1:0]           lk_vaddr,
  input  logic [1:0]                lk_kind,
  output logic                      lk_hit,
  output logic                      lk_miss,
  output logic                      lk_fault,
  output logic                      lk_wr_clean,
  output logic                      lk_multi,
  output logic [PA_W-1:0]           lk_paddr,
  input  logic                      fill_valid,
  output logic                      fill_ready,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic [1:0]                fill_acc,
  input  logic                      fill_dirty,
  input  logic                      inv_all,
  input  logic                      ref_clr
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned PPN_W = PA_W - PAGE_BITS;
  localparam int unsigned TAG_W = VPN_W - SET_BITS;

  logic [PAGE_BITS-1:0] lk_off;
  logic [SET_BITS-1:0]  lk_idx, fl_idx;
  logic [TAG_W-1:0]     lk_tag, fl_tag;

  assign lk_off = lk_vaddr[PAGE_BITS-1:0];
  assign lk_idx = lk_vaddr[PAGE_BITS +: SET_BITS];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign fl_idx = fill_vpn[SET_BITS-1:0];
  assign fl_tag = fill_vpn[VPN_W-1 -: TAG_W];

  assign lk_ready   = !inv_all;
  assign fill_ready = !inv_all;

  logic lk_fire, fill_fire;
  assign lk_fire   = lk_valid && lk_ready;
  assign fill_fire = fill_valid && fill_ready;

  logic [TLB_WAYS-1:0] w_valid, w_dirty, w_match, w_mark, w_wr, w_fvalid, w_fref;
  logic [TAG_W-1:0]    w_tag [TLB_WAYS];
  logic [PPN_W-1:0]    w_ppn [TLB_WAYS];
  logic [1:0]          w_acc [TLB_WAYS];

  logic victim, sel, single, allowed, is_write;

  assign is_write = (kind_e'(lk_kind) == KIND_WRITE);

  for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
    tlb_way #(
      .SET_BITS(SET_BITS),
      .TAG_W   (TAG_W),
      .PPN_W   (PPN_W)
    ) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (lk_idx),
      .rd_valid  (w_valid[w]),
      .rd_tag    (w_tag[w]),
      .rd_ppn    (w_ppn[w]),
      .rd_acc    (w_acc[w]),
      .rd_dirty  (w_dirty[w]),
      .fl_idx    (fl_idx),
      .fl_valid  (w_fvalid[w]),
      .fl_ref    (w_fref[w]),
      .wr_en     (w_wr[w]),
      .wr_tag    (fl_tag),
      .wr_ppn    (fill_ppn),
      .wr_acc    (fill_acc),
      .wr_dirty  (fill_dirty),
      .mark_en   (w_mark[w]),
      .mark_dirty(is_write),
      .inv_all   (inv_all),
      .ref_clr   (ref_clr)
    );
    assign w_match[w] = w_valid[w] && (w_tag[w] == lk_tag);
    assign w_mark[w]  = lk_hit && allowed && w_match[w];
    assign w_wr[w]    = fill_fire && (int'(victim) == w);
  end

  tlb_victim u_victim (
    .way_valid(w_fvalid),
    .way_ref  (w_fref),
    .victim   (victim)
  );

  assign single = w_match[0] ^ w_match[1];
  assign sel    = w_match[1];

  tlb_perm u_perm (
    .acc    (w_acc[sel]),
    .kind   (lk_kind),
    .allowed(allowed)
  );

  assign lk_hit      = lk_fire && single;
  assign lk_miss     = lk_fire && !single;
  assign lk_multi    = lk_fire && (&w_match);
  assign lk_fault    = lk_hit && !allowed;
  assign lk_wr_clean = lk_hit && allowed && is_write && !w_dirty[sel];
  assign lk_paddr    = lk_hit ? {w_ppn[sel], lk_off} : '0;
endmodule

// File: rtl/tlb2w_xlate_chk.sv
module tlb2w_xlate_chk #(
  parameter int unsigned VA_W      = 40,
  parameter int unsigned PAGE_BITS = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [1:0]      lk_kind,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic            lk_fault,
  input logic            lk_wr_clean,
  input logic            lk_multi,
  input logic            fill_valid,
  input logic            fill_ready,
  input logic            inv_all
);
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R9
  multi_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> (lk_miss && !lk_hit));

  // R4
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && !lk_wr_clean));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |-> !(lk_hit || lk_miss || lk_fault || lk_wr_clean || lk_multi));

  // R8
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  // R6
  wr_clean_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_wr_clean) && !$past(fill_valid && fill_ready) && lk_valid && lk_ready
     && lk_kind == 2'd1 && lk_vaddr == $past(lk_vaddr)) |-> !lk_wr_clean);
endmodule

bind tlb2w_xlate tlb2w_xlate_chk #(
  .VA_W     (VA_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_vaddr   (lk_vaddr),
  .lk_kind    (lk_kind),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_fault   (lk_fault),
  .lk_wr_clean(lk_wr_clean),
  .lk_multi   (lk_multi),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .inv_all    (inv_all)
);

// File: tb/sim_tlb2w_xlate.sv
module sim_tlb2w_xlate;
  localparam int VA_W = 20, PA_W = 18, PAGE_BITS = 6, SET_BITS = 3;
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0, inv_all = 1'b0, ref_clr = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [1:0] lk_kind = 2'd0, fill_acc = 2'd0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic lk_ready, fill_ready, lk_hit, lk_miss, lk_fault, lk_wr_clean, lk_multi;
  logic [PA_W-1:0] lk_paddr;

  int checks = 0, errors = 0;
  logic s_hit, s_miss, s_fault, s_wrc, s_multi;
  logic [PA_W-1:0] s_pa;

  always #4 clk = ~clk;

  tlb2w_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_wr_clean(lk_wr_clean), .lk_multi(lk_multi), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_acc(fill_acc), .fill_dirty(fill_dirty), .inv_all(inv_all), .ref_clr(ref_clr));

  function automatic logic [PPN_W-1:0] ppn_of(input int vpn);
    return PPN_W'((vpn * 13 + 7) & ((1 << PPN_W) - 1));
  endfunction

  function automatic int vpn_of(input int tag, input int set);
    return tag * (1 << SET_BITS) + set;
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input int vpn, input int off, input int kind, input logic clr);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {VPN_W'(vpn), PAGE_BITS'(off)};
    lk_kind  = 2'(kind);
    ref_clr  = clr;
    #2;
    s_hit = lk_hit; s_miss = lk_miss; s_fault = lk_fault;
    s_wrc = lk_wr_clean; s_multi = lk_multi; s_pa = lk_paddr;
    @(posedge clk);
    #1 lk_valid = 1'b0; ref_clr = 1'b0;
  endtask

  task automatic fill(input int vpn, input int ppn, input int acc, input logic dirty);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = VPN_W'(vpn);
    fill_ppn   = PPN_W'(ppn);
    fill_acc   = 2'(acc);
    fill_dirty = dirty;
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    inv_all  = 1'b1;
    lk_valid = 1'b1;
    #2;
    // R8 both readies drop; R10 nothing reported while not accepted
    chk(!lk_ready && !fill_ready, "R8 ready low during flush", {lk_ready, fill_ready}, 0);
    chk(!lk_hit && !lk_miss, "R10 quiet when not accepted", {lk_hit, lk_miss}, 0);
    @(posedge clk);
    #1 inv_all = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input int vpn, input int off, input string req);
    look(vpn, off, 0, 1'b0);
    chk(s_hit && !s_miss, req, {s_hit, s_miss}, 2);
    chk(s_pa == {ppn_of(vpn), PAGE_BITS'(off)}, req, s_pa, {ppn_of(vpn), PAGE_BITS'(off)});
  endtask

  task automatic expect_miss(input int vpn, input string req);
    look(vpn, 0, 0, 1'b0);
    chk(s_miss && !s_hit && s_pa == '0, req, {s_hit, s_miss}, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(lk_ready && fill_ready, "R1 readies after reset", {lk_ready, fill_ready}, 3);
    // R10 idle lookup quiet
    #2 chk(!lk_hit && !lk_miss, "R10 idle quiet", {lk_hit, lk_miss}, 0);
    for (int s = 0; s < 8; s++) expect_miss(vpn_of(s + 1, s), "R1 empty after reset");

    // R2 / R7: two tags per set, invalid way filled first
    for (int s = 0; s < 8; s++) begin
      fill(vpn_of(s + 1, s), ppn_of(vpn_of(s + 1, s)), 2, 1'b0);
      fill(vpn_of(s + 20, s), ppn_of(vpn_of(s + 20, s)), 1, 1'b0);
    end
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < 3; o++) begin
        int off = (o == 0) ? 0 : (o == 1) ? 63 : s * 7;
        expect_hit(vpn_of(s + 1, s), off, "R2 hit way A");
        expect_hit(vpn_of(s + 20, s), off, "R7 invalid way used, R2 hit way B");
      end
    end
    // R3 miss and no state change
    expect_miss(vpn_of(30, 3), "R3 miss unknown tag");
    expect_hit(vpn_of(4, 3), 5, "R3 state unchanged after miss");
    // R10 not valid
    @(negedge clk);
    lk_vaddr = {VPN_W'(vpn_of(4, 3)), 6'd0};
    #2 chk(!lk_hit && !lk_miss, "R10 no valid no result", {lk_hit, lk_miss}, 0);

    // R8 flush
    flush();
    for (int s = 0; s < 8; s++) expect_miss(vpn_of(s + 1, s), "R8 miss after flush");

    // R4 permission sweep, R6 first write reported
    for (int a = 0; a < 4; a++) fill(vpn_of(a + 1, a), ppn_of(vpn_of(a + 1, a)), a, 1'b0);
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 4; k++) begin
        logic ok;
        ok = (k == 0 && a != 0) || (k == 1 && a == 2) || (k == 2 && a == 3);
        look(vpn_of(a + 1, a), 9, k, 1'b0);
        chk(s_hit, "R4 hit under any code", s_hit, 1);
        chk(s_fault == !ok, "R4 fault per code and kind", s_fault, !ok);
        chk(s_wrc == (k == 1 && a == 2), "R6 write to clean", s_wrc, (k == 1 && a == 2));
      end
    end
    look(vpn_of(3, 2), 1, 1, 1'b0);
    chk(!s_wrc && s_hit, "R6 second write not reported", s_wrc, 0);
    fill(vpn_of(2, 5), ppn_of(vpn_of(2, 5)), 2, 1'b1);
    look(vpn_of(2, 5), 1, 1, 1'b0);
    chk(!s_wrc && s_hit, "R6 dirty fill not reported", s_wrc, 0);
    // R4 faulting write leaves dirty clear
    fill(vpn_of(4, 6), ppn_of(vpn_of(4, 6)), 1, 1'b0);
    look(vpn_of(4, 6), 0, 1, 1'b0);
    chk(s_fault && !s_wrc, "R4 fault write", s_fault, 1);

    // R7 / R5 replacement in set 6
    flush();
    fill(vpn_of(1, 6), ppn_of(vpn_of(1, 6)), 2, 1'b0);
    fill(vpn_of(2, 6), ppn_of(vpn_of(2, 6)), 2, 1'b0);
    fill(vpn_of(3, 6), ppn_of(vpn_of(3, 6)), 2, 1'b0);
    expect_miss(vpn_of(1, 6), "R7 tie both clear evicts way 0");
    expect_hit(vpn_of(2, 6), 0, "R7 way 1 kept");
    expect_hit(vpn_of(3, 6), 0, "R7 new entry in way 0");
    fill(vpn_of(4, 6), ppn_of(vpn_of(4, 6)), 2, 1'b0);
    expect_miss(vpn_of(3, 6), "R7 tie both set evicts way 0");
    expect_hit(vpn_of(4, 6), 0, "R7 new entry after tie");
    expect_hit(vpn_of(2, 6), 0, "R7 way 1 kept on tie");
    @(negedge clk); ref_clr = 1'b1; @(posedge clk); #1 ref_clr = 1'b0;
    expect_hit(vpn_of(4, 6), 0, "R5 reference way 0");
    fill(vpn_of(5, 6), ppn_of(vpn_of(5, 6)), 2, 1'b0);
    expect_miss(vpn_of(2, 6), "R5 cleared reference makes way 1 victim");
    expect_hit(vpn_of(4, 6), 0, "R5 referenced way 0 kept");
    expect_hit(vpn_of(5, 6), 0, "R7 new entry in way 1");
    look(vpn_of(4, 6), 0, 0, 1'b1);
    chk(s_hit, "R5 hit during clear", s_hit, 1);
    fill(vpn_of(6, 6), ppn_of(vpn_of(6, 6)), 2, 1'b0);
    expect_miss(vpn_of(4, 6), "R5 clear wins over same-cycle hit");
    expect_hit(vpn_of(5, 6), 0, "R5 way 1 kept");
    expect_hit(vpn_of(6, 6), 0, "R5 new entry in way 0");

    // R9 duplicate tag
    flush();
    fill(vpn_of(9, 7), 12, 2, 1'b0);
    fill(vpn_of(9, 7), 34, 2, 1'b0);
    look(vpn_of(9, 7), 3, 0, 1'b0);
    chk(s_miss && s_multi && !s_hit && s_pa == '0, "R9 multi match", {s_hit, s_miss, s_multi}, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule